// File: doc/BRIEF.md
# Timer Block Register Interface

This block is the software-visible register file of a multi-channel event timer. It decodes a 1 KiB address window holding a read-only capability word, a global configuration word, an interrupt status word, a free-running main counter and one register group per timer channel (configuration, comparator, interrupt route). Accesses of 1, 2, 4 or 8 bytes are accepted. Narrow reads return the addressed bytes right-aligned. Narrow writes replace only their own byte lanes in the 64-bit register.

The main counter advances once per 16 ns tick while the global enable bit is set, and holds its value while the bit is clear. The comparator match logic and the interrupt delivery sit outside this block. They receive single-cycle stop and start requests whenever a register write changes the run state of a channel. They report expiries back through a per-channel fire input that sets the matching status bit. All stop requests caused by one write come out one cycle before the start requests from the same write, so an external channel always sees a restart as a stop followed by a start.

Top module: `tmr_regfile`

## Requirements
- R1: After reset the global configuration, status, main counter and route registers read 0, each comparator reads all ones, and each timer configuration reads 64'h00F0_0000_0000_0030 (read-only route capability in bits 55:52, periodic-capable bit 4 and 64-bit-capable bit 5).
- R2: Only the low 10 address bits are decoded, and address bits 2:0 only choose byte lanes. Capability is at 0x000, global configuration at 0x010, status at 0x020, main counter at 0x0F0. Timer n has configuration at 0x100+0x20·n, comparator at +0x08 and route at +0x10.
- R3: An access whose length is not 1, 2, 4 or 8 bytes, or whose address is not a multiple of its length, is rejected. A rejected read returns all ones and a rejected write changes nothing.
- R4: A read of fewer than 8 bytes returns the register shifted right by 8·(address mod 8) bits and masked to the access width. Every read is answered one cycle later with rsp_valid.
- R5: A write of fewer than 8 bytes changes only the byte lanes it covers, and the other bits keep their old values.
- R6: In the global configuration only bit 0 (counter enable) and bit 1 (legacy routing) are writable. In a timer configuration only bit 1 (level), bit 2 (enable), bit 3 (periodic), bit 6 (set-value), bit 8 (32-bit mode) and bits 13:9 (route) are writable. The capability register ignores writes.
- R7: The capability register reads 64'h00F4_2400_8086_A201. This is 0x80860001 with the channel count minus one in bits 12:8, the 64-bit counter flag in bit 13, the legacy-capable flag in bit 15, and the tick period of 16,000,000 fs in bits 63:32.
- R8: With enable set, the main counter increases by one every 16 ns, first 16 ns after the enabling write. With enable clear it holds. A write loads it in either state.
- R9: A write that sets the global enable requests a start for every enabled channel. A write that clears it requests a stop for every enabled channel.
- R10: A main-counter write while the counter runs pulses cnt_warn and requests a stop and then a start for every enabled channel. The same write while halted does neither.
- R11: Stop requests from one write appear in the cycle after the write, and start requests from that write appear in the following cycle.
- R12: While the global enable is set, a channel configuration write that turns the channel on requests a start, and one that turns it off requests a stop. Toggling the periodic bit of an enabled channel requests both. A comparator write to an enabled channel also requests both. While the global enable is clear none of these requests anything.
- R13: A fire_in bit sets status bit n. Writing a one to status bit n clears it, and a fire in the same cycle wins over the clear.
- R14: Offsets that hold no register, including groups of absent channels, read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address (low 10 bits decoded) |
| req_len | input | 4 | Access length in bytes |
| req_wdata | input | 64 | Write data, right-aligned |
| fire_in | input | NUM_TIMERS | Channel expiry, sets status bit |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data, right-aligned |
| stop_req | output | NUM_TIMERS | One-cycle stop request per channel |
| start_req | output | NUM_TIMERS | One-cycle start request per channel |
| cnt_warn | output | 1 | Main counter written while running |

## Verification
Two pairs of functions can coincide in one cycle. The first pair is an expiry report and a write-one-to-clear of the same status bit. The bench drives fire_in for a channel in the very cycle it writes a one to that bit, then reads the status back. It judges the result correct only if the bit is still set. The second pair is a running counter and a counter write. Here the bench loads the counter while it runs and checks that the warning pulse and the stop vector for the enabled channels appear together, and that the identical start vector follows exactly one cycle later.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int WORD_W  = 64;
    localparam int WIN_W   = 10;
    localparam int TGRP_LG = 5;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_CAP,
        RK_GCFG,
        RK_STAT,
        RK_CNT,
        RK_TCFG,
        RK_TCMP,
        RK_TROUTE
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [4:0] idx;
    } reg_sel_t;

    localparam logic [WIN_W-1:0] OFS_CAP   = 10'h000;
    localparam logic [WIN_W-1:0] OFS_GCFG  = 10'h010;
    localparam logic [WIN_W-1:0] OFS_STAT  = 10'h020;
    localparam logic [WIN_W-1:0] OFS_CNT   = 10'h0F0;
    localparam logic [WIN_W-1:0] OFS_TBASE = 10'h100;

    // global configuration bits
    localparam int GC_RUN = 0;
    localparam int GC_LEG = 1;
    localparam word_t GCFG_WMASK = 64'h0000_0000_0000_0003;

    // channel configuration bits
    localparam int TC_LEVEL = 1;
    localparam int TC_EN    = 2;
    localparam int TC_PER   = 3;
    localparam int TC_SETV  = 6;
    localparam int TC_W32   = 8;
    localparam word_t TCFG_WMASK = 64'h0000_0000_0000_3F4E;
    localparam word_t TCFG_RO    = 64'h00F0_0000_0000_0030;

    function automatic word_t lane_merge(input word_t nv, input word_t ov, input word_t m);
        return (nv & m) | (ov & ~m);
    endfunction

    function automatic reg_sel_t decode_reg(input logic [WIN_W-1:0] a, input int unsigned ntim);
        reg_sel_t          s;
        logic [WIN_W-1:0]  q;
        logic [WIN_W-1:0]  off;
        q      = {a[WIN_W-1:3], 3'b000};
        off    = q - OFS_TBASE;
        s.kind = RK_NONE;
        s.idx  = '0;
        case (q)
            OFS_CAP:  s.kind = RK_CAP;
            OFS_GCFG: s.kind = RK_GCFG;
            OFS_STAT: s.kind = RK_STAT;
            OFS_CNT:  s.kind = RK_CNT;
            default: begin
                if (q >= OFS_TBASE && 32'(off[WIN_W-1:TGRP_LG]) < ntim) begin
                    s.idx = off[WIN_W-1:TGRP_LG];
                    case (off[TGRP_LG-1:3])
                        2'd0:    s.kind = RK_TCFG;
                        2'd1:    s.kind = RK_TCMP;
                        2'd2:    s.kind = RK_TROUTE;
                        default: s.kind = RK_NONE;
                    endcase
                end
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/tmr_access.sv
module tmr_access
    import tmr_pkg::*;
(
    input  logic [2:0] byte_ofs,
    input  logic [3:0] len,
    input  word_t      wdata,
    input  word_t      rd_full,
    output logic       ok,
    output word_t      lane_mask,
    output word_t      wdata_sh,
    output word_t      rd_fmt
);

    logic [5:0] sh_bits;
    word_t      width_mask;
    logic       len_legal;

    always_comb begin
        len_legal  = (len == 4'd1) || (len == 4'd2) || (len == 4'd4) || (len == 4'd8);
        ok         = len_legal && ((byte_ofs & (len[2:0] - 3'd1)) == 3'd0);
        sh_bits    = {byte_ofs, 3'b000};
        width_mask = (len == 4'd8) ? '1 : ((word_t'(1) << {len, 3'b000}) - word_t'(1));
        lane_mask  = width_mask << sh_bits;
        wdata_sh   = wdata << sh_bits;
        rd_fmt     = (rd_full >> sh_bits) & width_mask;
    end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  run,
    input  logic  load,
    input  word_t load_val,
    output word_t count
);

    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [PW-1:0] pre_q;
    word_t         cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            pre_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
            pre_q <= '0;
        end else if (!run) begin
            pre_q <= '0;
        end else if (pre_q == PW'(DIV - 1)) begin
            pre_q <= '0;
            cnt_q <= cnt_q + word_t'(1);
        end else begin
            pre_q <= pre_q + PW'(1);
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  glob_en,
    input  logic  wr_cfg,
    input  logic  wr_cmp,
    input  logic  wr_route,
    input  word_t wdata_sh,
    input  word_t lane_mask,
    output word_t cfg,
    output word_t cmp,
    output word_t route,
    output logic  want_stop,
    output logic  want_start
);

    word_t cfg_q, cmp_q, route_q;
    word_t cfg_new;
    logic  en_old, en_new, per_chg;

    always_comb begin
        cfg_new    = (lane_merge(wdata_sh, cfg_q, lane_mask) & TCFG_WMASK) | TCFG_RO;
        en_old     = cfg_q[TC_EN];
        en_new     = cfg_new[TC_EN];
        per_chg    = cfg_new[TC_PER] ^ cfg_q[TC_PER];
        want_stop  = glob_en && ((wr_cfg && en_old && (!en_new || per_chg)) ||
                                 (wr_cmp && en_old));
        want_start = glob_en && ((wr_cfg && en_new && (!en_old || per_chg)) ||
                                 (wr_cmp && en_old));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= TCFG_RO;
            cmp_q   <= '1;
            route_q <= '0;
        end else begin
            if (wr_cfg)   cfg_q   <= cfg_new;
            if (wr_cmp)   cmp_q   <= lane_merge(wdata_sh, cmp_q, lane_mask);
            if (wr_route) route_q <= lane_merge(wdata_sh, route_q, lane_mask);
        end
    end

    assign cfg   = cfg_q;
    assign cmp   = cmp_q;
    assign route = route_q;

endmodule

// File: rtl/tmr_sequencer.sv
module tmr_sequencer #(
    parameter int NT = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NT-1:0] stop_vec,
    input  logic [NT-1:0] start_vec,
    input  logic          warn_in,
    output logic [NT-1:0] stop_req,
    output logic [NT-1:0] start_req,
    output logic          warn
);

    logic [NT-1:0] stop_q, start_hold_q, start_q;
    logic          warn_q;

    // stops leave one cycle after the write, starts one cycle later still
    always_ff @(posedge clk) begin
        if (rst) begin
            stop_q       <= '0;
            start_hold_q <= '0;
            start_q      <= '0;
            warn_q       <= 1'b0;
        end else begin
            stop_q       <= stop_vec;
            start_hold_q <= start_vec;
            start_q      <= start_hold_q;
            warn_q       <= warn_in;
        end
    end

    assign stop_req  = stop_q;
    assign start_req = start_q;
    assign warn      = warn_q;

endmodule

// File: rtl/tmr_regfile.sv
module tmr_regfile
    import tmr_pkg::*;
#(
    parameter int NUM_TIMERS = 3,
    parameter int ADDR_W     = 16,
    parameter int CLK_NS     = 4,
    parameter int TICK_NS    = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [3:0]            req_len,
    input  logic [63:0]           req_wdata,
    input  logic [NUM_TIMERS-1:0] fire_in,
    output logic                  rsp_valid,
    output logic [63:0]           rsp_rdata,
    output logic [NUM_TIMERS-1:0] stop_req,
    output logic [NUM_TIMERS-1:0] start_req,
    output logic                  cnt_warn
);

    localparam int    DIV      = TICK_NS / CLK_NS;
    localparam int    TICK_FS  = TICK_NS * 1000000;
    localparam word_t CAP_WORD = {32'(TICK_FS),
                                  32'h8086_0001 | (32'(NUM_TIMERS - 1) << 8) | 32'h0000_A000};

    logic [WIN_W-1:0] win;
    logic             unused_addr_hi;
    reg_sel_t         sel;
    word_t            rd_full, rd_fmt, lane_mask, wdata_sh;
    logic             acc_ok, wr_fire, rd_fire;

    assign win            = req_addr[WIN_W-1:0];
    assign unused_addr_hi = ^req_addr[ADDR_W-1:WIN_W];
    assign sel            = decode_reg(win, NUM_TIMERS);

    tmr_access u_access (
        .byte_ofs (win[2:0]),
        .len      (req_len),
        .wdata    (req_wdata),
        .rd_full  (rd_full),
        .ok       (acc_ok),
        .lane_mask(lane_mask),
        .wdata_sh (wdata_sh),
        .rd_fmt   (rd_fmt)
    );

    assign wr_fire = req_valid && req_write && acc_ok;
    assign rd_fire = req_valid && !req_write;

    logic wr_gcfg, wr_stat, wr_cnt;
    assign wr_gcfg = wr_fire && (sel.kind == RK_GCFG);
    assign wr_stat = wr_fire && (sel.kind == RK_STAT);
    assign wr_cnt  = wr_fire && (sel.kind == RK_CNT);

    // global configuration
    word_t gcfg_q, gcfg_new;
    logic  glob_en, g_rise, g_fall, cnt_wr_run;
    assign gcfg_new   = lane_merge(wdata_sh, gcfg_q, lane_mask) & GCFG_WMASK;
    assign glob_en    = gcfg_q[GC_RUN];
    assign g_rise     = wr_gcfg && !gcfg_q[GC_RUN] && gcfg_new[GC_RUN];
    assign g_fall     = wr_gcfg && gcfg_q[GC_RUN] && !gcfg_new[GC_RUN];
    assign cnt_wr_run = wr_cnt && glob_en;

    always_ff @(posedge clk) begin
        if (rst) gcfg_q <= '0;
        else if (wr_gcfg) gcfg_q <= gcfg_new;
    end

    // main counter
    word_t count;
    tmr_counter #(.DIV(DIV)) u_counter (
        .clk     (clk),
        .rst     (rst),
        .run     (glob_en),
        .load    (wr_cnt),
        .load_val(lane_merge(wdata_sh, count, lane_mask)),
        .count   (count)
    );

    // status, write one to clear, fire wins
    logic [NUM_TIMERS-1:0] stat_q, stat_clr;
    word_t                 clr_word;
    assign clr_word = wdata_sh & lane_mask;
    assign stat_clr = wr_stat ? clr_word[NUM_TIMERS-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else stat_q <= (stat_q & ~stat_clr) | fire_in;
    end

    // channels
    word_t                 t_cfg   [NUM_TIMERS];
    word_t                 t_cmp   [NUM_TIMERS];
    word_t                 t_route [NUM_TIMERS];
    logic [NUM_TIMERS-1:0] ch_stop, ch_start, en_vec;

    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_chan
        logic hit;
        assign hit = wr_fire && (sel.idx == 5'(g));
        tmr_channel u_chan (
            .clk       (clk),
            .rst       (rst),
            .glob_en   (glob_en),
            .wr_cfg    (hit && (sel.kind == RK_TCFG)),
            .wr_cmp    (hit && (sel.kind == RK_TCMP)),
            .wr_route  (hit && (sel.kind == RK_TROUTE)),
            .wdata_sh  (wdata_sh),
            .lane_mask (lane_mask),
            .cfg       (t_cfg[g]),
            .cmp       (t_cmp[g]),
            .route     (t_route[g]),
            .want_stop (ch_stop[g]),
            .want_start(ch_start[g])
        );
        assign en_vec[g] = t_cfg[g][TC_EN];
    end

    logic [NUM_TIMERS-1:0] stop_vec, start_vec;
    assign stop_vec  = ch_stop  | ({NUM_TIMERS{g_fall || cnt_wr_run}} & en_vec);
    assign start_vec = ch_start | ({NUM_TIMERS{g_rise || cnt_wr_run}} & en_vec);

    tmr_sequencer #(.NT(NUM_TIMERS)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .stop_vec (stop_vec),
        .start_vec(start_vec),
        .warn_in  (cnt_wr_run),
        .stop_req (stop_req),
        .start_req(start_req),
        .warn     (cnt_warn)
    );

    // read multiplexer
    always_comb begin
        rd_full = '0;
        case (sel.kind)
            RK_CAP:  rd_full = CAP_WORD;
            RK_GCFG: rd_full = gcfg_q;
            RK_STAT: rd_full = word_t'(stat_q);
            RK_CNT:  rd_full = count;
            default: ;
        endcase
        for (int i = 0; i < NUM_TIMERS; i++) begin
            if (sel.idx == 5'(i)) begin
                case (sel.kind)
                    RK_TCFG:   rd_full = t_cfg[i];
                    RK_TCMP:   rd_full = t_cmp[i];
                    RK_TROUTE: rd_full = t_route[i];
                    default: ;
                endcase
            end
        end
    end

    logic  rsp_valid_q;
    word_t rsp_rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_q <= 1'b0;
            rsp_rdata_q <= '0;
        end else begin
            rsp_valid_q <= rd_fire;
            if (rd_fire) rsp_rdata_q <= acc_ok ? rd_fmt : '1;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_rdata = rsp_rdata_q;

endmodule

// File: rtl/tmr_regfile_chk.sv
module tmr_regfile_chk #(
    parameter int NT = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_write,
    input logic          acc_ok,
    input logic          rsp_valid,
    input logic [63:0]   rsp_rdata,
    input logic          glob_en,
    input logic          cnt_load,
    input logic [63:0]   count,
    input logic [NT-1:0] fire_in,
    input logic [NT-1:0] stat,
    input logic [NT-1:0] stop_req,
    input logic [NT-1:0] start_req,
    input logic          cnt_warn
);

    AST_REJECT_ONES: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && !acc_ok) |=> (rsp_valid && rsp_rdata == '1)); // R3

    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && !req_write)); // R4

    AST_CNT_HELD: assert property (@(posedge clk) disable iff (rst)
        (!glob_en && !cnt_load) |=> $stable(count)); // R8

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (glob_en && !cnt_load) |=> (count == $past(count) || count == $past(count) + 64'd1)); // R8

    AST_WARN_RESTART: assert property (@(posedge clk) disable iff (rst)
        cnt_warn |=> (start_req == $past(stop_req))); // R10

    AST_FIRE_SETS: assert property (@(posedge clk) disable iff (rst)
        (|fire_in) |=> ((stat & $past(fire_in)) == $past(fire_in))); // R13

endmodule

bind tmr_regfile tmr_regfile_chk #(.NT(NUM_TIMERS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_write(req_write),
    .acc_ok   (acc_ok),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata),
    .glob_en  (glob_en),
    .cnt_load (wr_cnt),
    .count    (count),
    .fire_in  (fire_in),
    .stat     (stat_q),
    .stop_req (stop_req),
    .start_req(start_req),
    .cnt_warn (cnt_warn)
);

// File: tb/tmr_regfile_test.sv
`timescale 1ns/1ps
module tmr_regfile_test;

    localparam int NT = 3;
    localparam logic [63:0] CAP   = 64'h00F4_2400_8086_A201;
    localparam logic [63:0] ONES  = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] T0CFG = 64'h00F0_0000_0000_3F7A;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [15:0]   req_addr = '0;
    logic [3:0]    req_len = '0;
    logic [63:0]   req_wdata = '0;
    logic [NT-1:0] fire_in = '0;
    logic          rsp_valid;
    logic [63:0]   rsp_rdata;
    logic [NT-1:0] stop_req, start_req;
    logic          cnt_warn;

    always #2 clk = ~clk;

    tmr_regfile #(.NUM_TIMERS(NT)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
        .fire_in(fire_in), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .stop_req(stop_req), .start_req(start_req), .cnt_warn(cnt_warn)
    );

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [3:0]  len;
        logic [63:0] data;
        logic [63:0] exp;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 33;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'h0000, 4'd8, 64'h0, CAP, 8'd7},                         // R7
        '{1'b0, 16'h0004, 4'd4, 64'h0, 64'h00F4_2400, 8'd4},               // R4
        '{1'b0, 16'h0001, 4'd1, 64'h0, 64'hA2, 8'd4},                      // R4
        '{1'b0, 16'h0002, 4'd4, 64'h0, ONES, 8'd3},                        // R3
        '{1'b0, 16'h0000, 4'd3, 64'h0, ONES, 8'd3},                        // R3
        '{1'b0, 16'h0000, 4'd9, 64'h0, ONES, 8'd3},                        // R3
        '{1'b1, 16'h0010, 4'd8, 64'hFFFF_FFFF_FFFF_FFFE, 64'h0, 8'd6},     // R6
        '{1'b0, 16'h0010, 4'd8, 64'h0, 64'h2, 8'd6},                       // R6
        '{1'b1, 16'h0000, 4'd8, ONES, 64'h0, 8'd6},                        // R6
        '{1'b0, 16'h0000, 4'd8, 64'h0, CAP, 8'd6},                         // R6
        '{1'b1, 16'h0100, 4'd8, 64'hFFFF_FFFF_FFFF_FFFB, 64'h0, 8'd6},     // R6
        '{1'b0, 16'h0100, 4'd8, 64'h0, T0CFG, 8'd6},                       // R6
        '{1'b1, 16'h0108, 4'd8, 64'h1122_3344_5566_7788, 64'h0, 8'd5},     // R5
        '{1'b1, 16'h010A, 4'd2, 64'hABCD, 64'h0, 8'd5},                    // R5
        '{1'b1, 16'h0109, 4'd1, 64'h5A, 64'h0, 8'd5},                      // R5
        '{1'b0, 16'h0108, 4'd8, 64'h0, 64'h1122_3344_ABCD_5A88, 8'd5},     // R5
        '{1'b1, 16'h010B, 4'd2, 64'h0, 64'h0, 8'd3},                       // R3
        '{1'b0, 16'h0108, 4'd8, 64'h0, 64'h1122_3344_ABCD_5A88, 8'd3},     // R3
        '{1'b0, 16'h0508, 4'd8, 64'h0, 64'h1122_3344_ABCD_5A88, 8'd2},     // R2
        '{1'b0, 16'h010C, 4'd4, 64'h0, 64'h1122_3344, 8'd4},               // R4
        '{1'b0, 16'hFC10, 4'd8, 64'h0, 64'h2, 8'd2},                       // R2
        '{1'b1, 16'h0030, 4'd8, ONES, 64'h0, 8'd14},                       // R14
        '{1'b0, 16'h0030, 4'd8, 64'h0, 64'h0, 8'd14},                      // R14
        '{1'b1, 16'h0118, 4'd8, ONES, 64'h0, 8'd14},                       // R14
        '{1'b0, 16'h0118, 4'd8, 64'h0, 64'h0, 8'd14},                      // R14
        '{1'b0, 16'h0110, 4'd8, 64'h0, 64'h0, 8'd14},                      // R14
        '{1'b1, 16'h0150, 4'd8, 64'hDEAD_BEEF_00C0_FFEE, 64'h0, 8'd2},     // R2
        '{1'b0, 16'h0150, 4'd8, 64'h0, 64'hDEAD_BEEF_00C0_FFEE, 8'd2},     // R2
        '{1'b0, 16'h0160, 4'd8, 64'h0, 64'h0, 8'd14},                      // R14
        '{1'b1, 16'h0160, 4'd8, ONES, 64'h0, 8'd14},                       // R14
        '{1'b0, 16'h0100, 4'd8, 64'h0, T0CFG, 8'd14},                      // R14
        '{1'b1, 16'h0010, 4'd1, 64'h0, 64'h0, 8'd5},                       // R5
        '{1'b0, 16'h0010, 4'd8, 64'h0, 64'h0, 8'd6}                        // R6
    };

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic          o_rv;
    logic [63:0]   o_rd;
    logic [NT-1:0] o_stop, o_start;
    logic          o_warn;

    task automatic chk(input string rq, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", rq, got, exp);
        end
    endtask

    // entered at a falling edge, returns at the next falling edge
    task automatic cyc(input logic v, input logic w, input logic [15:0] a,
                       input logic [3:0] l, input logic [63:0] d, input logic [NT-1:0] f);
        req_valid = v; req_write = w; req_addr = a; req_len = l; req_wdata = d; fire_in = f;
        @(negedge clk);
        o_rv = rsp_valid; o_rd = rsp_rdata; o_stop = stop_req; o_start = start_req; o_warn = cnt_warn;
        req_valid = 1'b0; req_write = 1'b0; fire_in = '0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [3:0] l, input logic [63:0] d);
        cyc(1'b1, 1'b1, a, l, d, '0);
    endtask

    task automatic rd(input logic [15:0] a, input logic [3:0] l);
        cyc(1'b1, 1'b0, a, l, 64'h0, '0);
    endtask

    task automatic idle();
        cyc(1'b0, 1'b0, 16'h0, 4'd0, 64'h0, '0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog got=%h exp=%h", 64'h0, 64'h1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();

        // vector table
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) begin
                wr(VECS[i].addr, VECS[i].len, VECS[i].data);
            end else begin
                rd(VECS[i].addr, VECS[i].len);
                chk($sformatf("R%0d vec%0d", VECS[i].rq, i), o_rd, VECS[i].exp);
            end
        end

        // R1 reset state
        do_reset();
        rd(16'h0010, 4'd8); chk("R1 gcfg", o_rd, 64'h0);
        chk("R4 rsp_valid", 64'(o_rv), 64'h1);
        rd(16'h0020, 4'd8); chk("R1 status", o_rd, 64'h0);
        rd(16'h00F0, 4'd8); chk("R1 counter", o_rd, 64'h0);
        rd(16'h0120, 4'd8); chk("R1 t1 cfg", o_rd, 64'h00F0_0000_0000_0030);
        rd(16'h0128, 4'd8); chk("R1 t1 cmp", o_rd, ONES);
        rd(16'h0150, 4'd8); chk("R1 t2 route", o_rd, 64'h0);

        // R8 counter load, run, hold
        wr(16'h00F0, 4'd8, 64'd100); chk("R10 halted load warn", 64'(o_warn), 64'h0);
        wr(16'h0010, 4'd8, 64'h1);
        idle(); chk("R9 no timers start", 64'(o_start), 64'h0);
        repeat (9) idle();
        wr(16'h0010, 4'd8, 64'h0);
        rd(16'h00F0, 4'd8); chk("R8 run count", o_rd, 64'd102);
        repeat (5) idle();
        rd(16'h00F0, 4'd8); chk("R8 hold count", o_rd, 64'd102);

        // R12 channel writes while halted
        wr(16'h0100, 4'd8, 64'h4); chk("R12 halted stop", 64'(o_stop), 64'h0);
        wr(16'h0140, 4'd8, 64'hC); chk("R12 halted start", 64'(o_start), 64'h0);
        idle(); chk("R12 halted start2", 64'(o_start), 64'h0);

        // R9 R11 enabling
        wr(16'h0010, 4'd8, 64'h1); chk("R11 enable stop", 64'(o_stop), 64'h0);
        idle(); chk("R9 enable start", 64'(o_start), 64'h5);

        // R10 counter write while running
        wr(16'h00F0, 4'd8, 64'd5);
        chk("R10 warn", 64'(o_warn), 64'h1);
        chk("R10 stop", 64'(o_stop), 64'h5);
        chk("R11 no start yet", 64'(o_start), 64'h0);
        idle(); chk("R11 start after stop", 64'(o_start), 64'h5);

        // R12 periodic toggle, comparator write, on/off
        wr(16'h0140, 4'd8, 64'h4); chk("R12 per stop", 64'(o_stop), 64'h4);
        idle(); chk("R12 per start", 64'(o_start), 64'h4);
        wr(16'h0108, 4'd8, 64'h77); chk("R12 cmp stop", 64'(o_stop), 64'h1);
        idle(); chk("R12 cmp start", 64'(o_start), 64'h1);
        wr(16'h0120, 4'd8, 64'h4); chk("R12 on stop", 64'(o_stop), 64'h0);
        idle(); chk("R12 on start", 64'(o_start), 64'h2);
        wr(16'h0100, 4'd8, 64'h0); chk("R12 off stop", 64'(o_stop), 64'h1);
        idle(); chk("R12 off start", 64'(o_start), 64'h0);

        // R9 disabling
        wr(16'h0010, 4'd8, 64'h0); chk("R9 disable stop", 64'(o_stop), 64'h6);
        idle(); chk("R9 disable start", 64'(o_start), 64'h0);
        wr(16'h00F0, 4'd8, 64'd0); chk("R10 halted warn", 64'(o_warn), 64'h0);
        chk("R10 halted stop", 64'(o_stop), 64'h0);

        // R13 status
        cyc(1'b0, 1'b0, 16'h0, 4'd0, 64'h0, 3'b010);
        rd(16'h0020, 4'd8); chk("R13 fire set", o_rd, 64'h2);
        cyc(1'b1, 1'b1, 16'h0020, 4'd8, 64'h2, 3'b010);
        rd(16'h0020, 4'd8); chk("R13 fire beats clear", o_rd, 64'h2);
        wr(16'h0020, 4'd8, 64'h2);
        rd(16'h0020, 4'd8); chk("R13 clear", o_rd, 64'h0);
        cyc(1'b0, 1'b0, 16'h0, 4'd0, 64'h0, 3'b101);
        wr(16'h0020, 4'd1, 64'h01);
        rd(16'h0020, 4'd8); chk("R13 partial clear", o_rd, 64'h4);
        wr(16'h0021, 4'd1, 64'hFF);
        rd(16'h0020, 4'd8); chk("R5 other lane no clear", o_rd, 64'h4);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule